// File: doc/BRIEF.md
# Segmented Data Memory Address Mapper

This block sits between a small processor core and its data RAM. The core presents an 8-bit offset, and an 8-bit segment register picks the bank for that offset. The block turns each access into a read or write of the right physical array. The base segment (segment 0) has a 112-byte general area at offsets 0x00–0x6F and a 16-byte register file at offsets 0xF0–0xFF. Offsets 0x70–0x7F of segment 0 are a hole with no storage behind them.

Nonzero segments add up to 128 bytes each at offsets 0x00–0x7F. The default build fits one such bank, segment 1, which covers full addresses 0x0100–0x017F. The upper half of the offset range never follows the segment register, so the register file can be reached from every segment. Accesses flagged as stack traffic always resolve in segment 0, whatever the segment register holds.

The block also holds the segment register and the stack pointer. Both are written through their own strobes and are visible on output ports. Reads return data one cycle after the read strobe, and unmapped locations read as all ones.

Top module: `segmap_top`

## Requirements
- R1: While reset is high and on the first cycle after it, the segment register reads 0x00, the stack pointer reads 0x6F and read data is 0xFF.
- R2: A segment write strobe loads the segment register at the next clock edge, and a stack-pointer write strobe loads the stack pointer the same way. Each value then appears on its output port.
- R3: Read data for a read strobe appears on the cycle after the strobe. A write lands at the clock edge where the write strobe is high. A read and a write to the same location in one cycle return the old content.
- R4: In segment 0, offsets 0x00–0x6F address 112 distinct bytes of general RAM.
- R5: Offsets 0xF0–0xFF address one 16-byte register file no matter what the segment register holds.
- R6: Unmapped locations read 0xFF and ignore writes. These are offsets 0x70–0x7F of segment 0, offsets 0x80–0xEF in any segment, and offsets 0x00–0x7F of segments above the number of extension banks.
- R7: Segment n, for n from 1 up to the number of extension banks, maps offsets 0x00–0x7F to its own 128-byte bank. This bank is separate from segment 0 at the same offsets.
- R8: An access with the stack qualifier high resolves in segment 0 whatever the segment register holds, and it leaves the segment register unchanged.
- R9: Read data holds its value on every cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe for the current offset |
| wr_en | input | 1 | Write strobe for the current offset |
| stk | input | 1 | Marks the access as stack traffic (forces segment 0) |
| addr | input | 8 | Data memory offset |
| wdata | input | 8 | Write data |
| seg_we | input | 1 | Load strobe for the segment register |
| seg_wdata | input | 8 | New segment register value |
| sp_we | input | 1 | Load strobe for the stack pointer |
| sp_wdata | input | 8 | New stack pointer value |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| seg_q | output | 8 | Current segment register |
| sp_q | output | 8 | Current stack pointer |

## Verification
The main checks are aliasing pairs. Different values go to the same offset in segments 0 and 1 and both are read back, which shows whether the banks are truly separate. The same pairs are then repeated with stack accesses while the segment register is nonzero, which shows whether the stack qualifier overrides the segment. Reads of the register file from segments 0, 1 and an unbacked segment show whether the upper offsets follow the segment register. Boundary offsets 0x6F/0x70, 0x7F/0x80 and 0xEF/0xF0, a write-then-read of unmapped cells, and a same-cycle read and write separate a correct region decode from an off-by-one one.

// File: rtl/segmap_pkg.sv
package segmap_pkg;

    localparam int DATA_W     = 8;
    localparam int OFF_W      = 8;
    localparam int SEG_W      = 8;
    localparam int LOW_DEPTH  = 112;
    localparam int FILE_DEPTH = 16;
    localparam int EXT_SPAN   = 128;
    localparam int FILE_BASE  = (1 << OFF_W) - FILE_DEPTH;
    localparam int LOW_AW     = $clog2(LOW_DEPTH);
    localparam int FILE_AW    = $clog2(FILE_DEPTH);
    localparam int EXT_AW     = $clog2(EXT_SPAN);

    typedef enum logic [1:0] {
        RGN_LOW  = 2'd0,
        RGN_FILE = 2'd1,
        RGN_EXT  = 2'd2,
        RGN_NONE = 2'd3
    } rgn_e;

    typedef struct packed {
        rgn_e             rgn;
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] idx;
    } dec_t;

    function automatic dec_t map_addr(input logic [SEG_W-1:0] seg,
                                      input logic             stk,
                                      input logic [OFF_W-1:0] off,
                                      input int               ext_segs);
        dec_t d;
        logic [SEG_W-1:0] eff;
        eff   = stk ? '0 : seg;
        d.rgn = RGN_NONE;
        d.seg = eff;
        d.idx = off;
        if (int'(off) >= FILE_BASE) begin
            d.rgn = RGN_FILE;
            d.idx = off - OFF_W'(FILE_BASE);
        end else if (int'(off) < EXT_SPAN) begin
            if (eff == '0) begin
                if (int'(off) < LOW_DEPTH) d.rgn = RGN_LOW;
            end else if (int'(eff) <= ext_segs) begin
                d.rgn = RGN_EXT;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/segmap_decode.sv
module segmap_decode
    import segmap_pkg::*;
#(
    parameter int EXT_SEGS = 1
) (
    input  logic [SEG_W-1:0] seg,
    input  logic             stk,
    input  logic [OFF_W-1:0] addr,
    output dec_t             dec
);
    always_comb dec = map_addr(seg, stk, addr, EXT_SEGS);
endmodule

// File: rtl/segmap_ram.sv
module segmap_ram
    import segmap_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata     <= mem[addr];
    end
endmodule

// File: rtl/segmap_regs.sv
module segmap_regs
    import segmap_pkg::*;
#(
    parameter logic [OFF_W-1:0] SP_INIT = 8'h6F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seg_we,
    input  logic [SEG_W-1:0] seg_wdata,
    input  logic             sp_we,
    input  logic [OFF_W-1:0] sp_wdata,
    output logic [SEG_W-1:0] seg_q,
    output logic [OFF_W-1:0] sp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= '0;
            sp_q  <= SP_INIT;
        end else begin
            if (seg_we) seg_q <= seg_wdata;
            if (sp_we)  sp_q  <= sp_wdata;
        end
    end
endmodule

// File: rtl/segmap_top.sv
module segmap_top
    import segmap_pkg::*;
#(
    parameter int               EXT_SEGS = 1,
    parameter logic [OFF_W-1:0] SP_INIT  = 8'h6F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              stk,
    input  logic [OFF_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              seg_we,
    input  logic [SEG_W-1:0]  seg_wdata,
    input  logic              sp_we,
    input  logic [OFF_W-1:0]  sp_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [SEG_W-1:0]  seg_q,
    output logic [OFF_W-1:0]  sp_q
);
    dec_t              dec;
    rgn_e              rgn_q;
    logic [SEG_W-1:0]  bank_q;
    logic [DATA_W-1:0] low_q, file_q, ext_mux;
    logic [DATA_W-1:0] ext_q [EXT_SEGS];

    segmap_regs #(.SP_INIT(SP_INIT)) u_regs (
        .clk(clk), .rst(rst),
        .seg_we(seg_we), .seg_wdata(seg_wdata),
        .sp_we(sp_we), .sp_wdata(sp_wdata),
        .seg_q(seg_q), .sp_q(sp_q)
    );

    segmap_decode #(.EXT_SEGS(EXT_SEGS)) u_dec (
        .seg(seg_q), .stk(stk), .addr(addr), .dec(dec)
    );

    segmap_ram #(.DEPTH(LOW_DEPTH)) u_low (
        .clk(clk),
        .we(wr_en && dec.rgn == RGN_LOW),
        .re(rd_en && dec.rgn == RGN_LOW),
        .addr(dec.idx[LOW_AW-1:0]),
        .wdata(wdata), .rdata(low_q)
    );

    segmap_ram #(.DEPTH(FILE_DEPTH)) u_file (
        .clk(clk),
        .we(wr_en && dec.rgn == RGN_FILE),
        .re(rd_en && dec.rgn == RGN_FILE),
        .addr(dec.idx[FILE_AW-1:0]),
        .wdata(wdata), .rdata(file_q)
    );

    for (genvar g = 0; g < EXT_SEGS; g++) begin : g_ext
        logic hit;
        assign hit = dec.rgn == RGN_EXT && dec.seg == SEG_W'(g + 1);
        segmap_ram #(.DEPTH(EXT_SPAN)) u_bank (
            .clk(clk),
            .we(wr_en && hit),
            .re(rd_en && hit),
            .addr(dec.idx[EXT_AW-1:0]),
            .wdata(wdata), .rdata(ext_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rgn_q  <= RGN_NONE;
            bank_q <= '0;
        end else if (rd_en) begin
            rgn_q  <= dec.rgn;
            bank_q <= dec.seg - SEG_W'(1);
        end
    end

    always_comb begin
        ext_mux = '1;
        for (int g = 0; g < EXT_SEGS; g++)
            if (bank_q == SEG_W'(g)) ext_mux = ext_q[g];
    end

    always_comb begin
        unique case (rgn_q)
            RGN_LOW:  rdata = low_q;
            RGN_FILE: rdata = file_q;
            RGN_EXT:  rdata = ext_mux;
            default:  rdata = '1;
        endcase
    end
endmodule

// File: rtl/segmap_chk.sv
module segmap_chk
    import segmap_pkg::*;
#(
    parameter logic [OFF_W-1:0] SP_INIT = 8'h6F
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              wr_en,
    input logic              stk,
    input logic [OFF_W-1:0]  addr,
    input logic              seg_we,
    input logic [SEG_W-1:0]  seg_wdata,
    input logic              sp_we,
    input logic [OFF_W-1:0]  sp_wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [SEG_W-1:0]  seg_q,
    input logic [OFF_W-1:0]  sp_q
);
    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (seg_q == '0 && sp_q == SP_INIT && rdata == '1));

    a_r2_seg_load: assert property (@(posedge clk) disable iff (rst)
        seg_we |=> seg_q == $past(seg_wdata));

    a_r2_sp_load: assert property (@(posedge clk) disable iff (rst)
        sp_we |=> sp_q == $past(sp_wdata));

    a_r8_stack_keeps_seg: assert property (@(posedge clk) disable iff (rst)
        (stk && (rd_en || wr_en) && !seg_we) |=> $stable(seg_q));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    a_r6_hole: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !stk && seg_q == '0 && addr >= 8'h70 && addr < 8'h80)
        |=> rdata == '1);

    a_r6_mid_gap: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr >= 8'h80 && addr < 8'hF0) |=> rdata == '1);
endmodule

bind segmap_top segmap_chk #(.SP_INIT(SP_INIT)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .stk(stk),
    .addr(addr), .seg_we(seg_we), .seg_wdata(seg_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata),
    .rdata(rdata), .seg_q(seg_q), .sp_q(sp_q)
);

// File: tb/segmap_top_test.sv
module segmap_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_en = 0, wr_en = 0, stk = 0, seg_we = 0, sp_we = 0;
    logic [7:0] addr = 0, wdata = 0, seg_wdata = 0, sp_wdata = 0;
    logic [7:0] rdata, seg_q, sp_q;

    always #5 clk = ~clk;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic chk_pend = 1'b0;
    bit   done = 1'b0;

    segmap_top uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .stk(stk),
        .addr(addr), .wdata(wdata), .seg_we(seg_we), .seg_wdata(seg_wdata),
        .sp_we(sp_we), .sp_wdata(sp_wdata),
        .rdata(rdata), .seg_q(seg_q), .sp_q(sp_q)
    );

    // monitor: a read issued before a posedge is compared at the next negedge
    always @(posedge clk) chk_pend <= rd_en && !rst;

    always @(negedge clk) begin
        exp_t e;
        if (chk_pend) begin
            n_cmp++;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: rdata=%h expected none", rdata);
            end else begin
                e = sbq.pop_front();
                if (rdata !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h expected %h", e.tag, rdata, e.val);
                end
            end
        end
    end

    task automatic clr();
        rd_en = 0; wr_en = 0; stk = 0; seg_we = 0; sp_we = 0;
    endtask

    task automatic idle();
        @(negedge clk); clr();
    endtask

    task automatic put(input logic [7:0] a, input logic s, input logic [7:0] d);
        @(negedge clk); clr();
        wr_en = 1; stk = s; addr = a; wdata = d;
    endtask

    task automatic get(input logic [7:0] a, input logic s,
                       input logic [7:0] ev, input string tag);
        exp_t e;
        @(negedge clk); clr();
        rd_en = 1; stk = s; addr = a;
        e.val = ev; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic rw(input logic [7:0] a, input logic [7:0] d,
                      input logic [7:0] ev, input string tag);
        exp_t e;
        @(negedge clk); clr();
        rd_en = 1; wr_en = 1; addr = a; wdata = d;
        e.val = ev; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic set_seg(input logic [7:0] v);
        @(negedge clk); clr();
        seg_we = 1; seg_wdata = v;
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] ev,
                         input string tag);
        n_cmp++;
        if (act !== ev) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, ev);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(seg_q, 8'h00, "R1 segment after reset");
        check(sp_q,  8'h6F, "R1 stack pointer after reset");
        check(rdata, 8'hFF, "R1 read data after reset");

        // R4 base general RAM, edges of the 112-byte area
        put(8'h00, 0, 8'hA3);
        put(8'h10, 0, 8'hA1);
        put(8'h6F, 0, 8'hA2);
        get(8'h00, 0, 8'hA3, "R4 seg0 off 00");
        get(8'h10, 0, 8'hA1, "R4 seg0 off 10");
        get(8'h6F, 0, 8'hA2, "R4 seg0 off 6F");

        // R3 read-during-write returns old content, then new
        put(8'h30, 0, 8'h40);
        rw(8'h30, 8'h41, 8'h40, "R3 same-cycle read sees old");
        get(8'h30, 0, 8'h41, "R3 write landed");

        // R2 / R7 segment 1 bank is separate from segment 0
        set_seg(8'h01);
        idle();
        check(seg_q, 8'h01, "R2 segment register load");
        put(8'h10, 0, 8'hB1);
        put(8'h20, 0, 8'hD1);
        put(8'h7F, 0, 8'hE1);
        get(8'h10, 0, 8'hB1, "R7 seg1 off 10 aliasing");
        get(8'h7F, 0, 8'hE1, "R7 seg1 off 7F");

        // R8 stack traffic with segment 1 selected goes to segment 0
        get(8'h10, 1, 8'hA1, "R8 stack read at seg1");
        put(8'h20, 1, 8'hC1);
        get(8'h75, 1, 8'hFF, "R8 stack read of seg0 hole");
        idle();
        check(seg_q, 8'h01, "R8 segment unchanged by stack traffic");
        get(8'h20, 0, 8'hD1, "R8 seg1 off 20 untouched by stack write");

        // R5 register file from segment 1
        put(8'hFF, 0, 8'h33);
        set_seg(8'h00);
        get(8'h20, 0, 8'hC1, "R8 stack write landed in seg0");
        get(8'h10, 0, 8'hA1, "R7 seg0 off 10 kept");
        get(8'hFF, 0, 8'h33, "R5 file byte seen from seg0");
        put(8'hF0, 0, 8'h11);

        // R6 segment 0 hole and mid gap
        put(8'h7F, 0, 8'h55);
        get(8'h7F, 0, 8'hFF, "R6 seg0 off 7F hole");
        get(8'h70, 0, 8'hFF, "R6 seg0 off 70 hole");
        put(8'h80, 0, 8'h66);
        get(8'h80, 0, 8'hFF, "R6 off 80 gap");
        get(8'hEF, 0, 8'hFF, "R6 off EF gap");

        // R6 segment without a bank, R5 file still reachable
        set_seg(8'h09);
        get(8'hF0, 0, 8'h11, "R5 file byte seen from seg9");
        put(8'h10, 0, 8'h77);
        get(8'h10, 0, 8'hFF, "R6 seg9 off 10 unbacked");
        get(8'h10, 1, 8'hA1, "R8 stack read at seg9");
        set_seg(8'h01);
        get(8'h10, 0, 8'hB1, "R6 seg9 write did not reach seg1");
        get(8'h7F, 0, 8'hE1, "R6 seg0 hole write did not reach seg1");

        // R9 read data holds with no read strobe
        idle();
        idle();
        check(rdata, 8'hE1, "R9 rdata held");
        put(8'h7F, 0, 8'h00);
        idle();
        check(rdata, 8'hE1, "R9 rdata held across write");

        // R2 stack pointer load
        @(negedge clk); clr();
        sp_we = 1; sp_wdata = 8'h50;
        idle();
        check(sp_q, 8'h50, "R2 stack pointer load");

        idle();
        idle();
        check(sbq.size(), 0, "scoreboard drained");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule